// File: doc/BRIEF.md
# Interrupt Context Save/Restore Sequencer

This block moves a processor's architectural register context into and out of a private hardware return stack when an interrupt is taken and when the handler returns. When an interrupt is accepted, the whole register file is snapshotted in a single cycle. A write that lands in that same cycle is forwarded into the snapshot. The live registers are then zeroed so that the handler cannot observe the interrupted program's data. The snapshot drains into the stack as a fixed number of beats, each carrying an equal slice of the register file. While the drain runs, the handler is free to read and write the now-cleared registers.

A return request pops the same beats back in reverse order and writes them into the live registers. A single `stall` output serves as the interlock towards the front end. It holds a return until the save has fully drained. It holds any register read or write while a restore is writing the registers. It holds a new interrupt while either sequence runs. Stack exhaustion in either direction is reported by a one-cycle flag, and the request that caused it is dropped.

Top module: `ctx_seq`

## Requirements
- R1: After synchronous reset every live register reads 0, the stack is empty, and `stall`, `save_busy`, `save_done`, `rest_busy`, `rest_done`, `stack_ovf` and `stack_unf` are all low.
- R2: An `irq_req` seen while idle, with room for one whole frame (BEATS beats), is accepted at that clock edge without stall. `save_busy` is then high for exactly BEATS cycles, starting in the cycle after acceptance. `save_done` is high only in the last of those cycles.
- R3: A register write presented in the same cycle as an accepted `irq_req` is part of the saved context, and the later restore returns it.
- R4: In the cycle after an interrupt is accepted, every live register reads 0.
- R5: During the save drain, handler register writes and reads proceed without stall and take effect at once.
- R6: A `reti_req` or `irq_req` raised while a save or restore is in progress asserts `stall` and is not accepted. A held return is accepted only once `save_busy` has fallen.
- R7: A `reti_req` seen while idle, with at least one frame on the stack and no simultaneous `irq_req`, starts a restore. `rest_busy` is high for exactly BEATS cycles, and `rest_done` is high in the last of them. Afterwards every register holds its saved value, and any handler write to it is overwritten.
- R8: While a restore runs, a presented register write or interrupt request asserts `stall`. A write dropped while stalled leaves the restored value intact.
- R9: A register read presented during a restore is stalled until the restore ends. The first read that completes returns the restored value.
- R10: An `irq_req` seen while idle without room for a frame pulses `stack_ovf` for that cycle without stall. It starts no save and does not clear the registers.
- R11: A `reti_req` seen while idle with an empty stack pulses `stack_unf` for that cycle without stall, and starts no restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt entry request |
| reti_req | input | 1 | Return-from-interrupt request |
| wr_en | input | 1 | Register write strobe from the pipeline |
| wr_idx | input | $clog2(NREG) | Register written |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe from the pipeline |
| rd_idx | input | $clog2(NREG) | Register read |
| rd_data | output | DW | Live value of the register selected by `rd_idx` |
| stall | output | 1 | Interlock: the presented request must be held or retried |
| save_busy | output | 1 | Save beats are being written to the stack |
| save_done | output | 1 | The last save beat is written this cycle |
| rest_busy | output | 1 | Restore beats are being written to the registers |
| rest_done | output | 1 | The last restore beat is written this cycle |
| stack_ovf | output | 1 | Interrupt refused: no room for a frame |
| stack_unf | output | 1 | Return refused: no frame on the stack |

## Verification
The bench builds the block with 16 registers of 16 bits in 8 beats, which gives two registers per beat, and with a stack depth of one frame. With a single frame, a second interrupt taken inside the handler reaches the overflow path, and a return from an empty stack reaches the underflow path, using only a few requests. With the short 8-cycle drain, the bench can place a handler write, a handler read and a held return inside the same save window. It can also land a stalled write and a stalled read inside one restore window.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAVE = 2'd1,
        PH_REST = 2'd2
    } ctx_phase_e;

    typedef struct packed {
        logic snap_clr;  // take snapshot and zero live registers
        logic push;      // write one save beat to the stack
        logic pop;       // read one restore beat from the stack
    } ctx_ctl_t;

    function automatic int regs_per_beat(input int nreg, input int beats);
        return nreg / beats;
    endfunction

endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
    import ctx_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int BCW = $clog2(BEATS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           irq_req,
    input  logic           reti_req,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic           room_ok,
    input  logic           frame_ok,
    output ctx_ctl_t       ctl,
    output ctx_phase_e     phase,
    output logic [BCW-1:0] beat,
    output logic           stall,
    output logic           save_busy,
    output logic           save_done,
    output logic           rest_busy,
    output logic           rest_done,
    output logic           stack_ovf,
    output logic           stack_unf
);

    localparam logic [BCW-1:0] LAST = BCW'(BEATS - 1);

    logic idle, irq_go, reti_go;

    assign idle    = (phase == PH_IDLE);
    assign irq_go  = idle && irq_req && room_ok;
    assign reti_go = idle && reti_req && !irq_go && !irq_req && frame_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            beat  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (irq_go) begin
                        phase <= PH_SAVE;
                        beat  <= '0;
                    end else if (reti_go) begin
                        phase <= PH_REST;
                        beat  <= LAST;
                    end
                end
                PH_SAVE: begin
                    if (beat == LAST) phase <= PH_IDLE;
                    else              beat  <= beat + 1'b1;
                end
                PH_REST: begin
                    if (beat == '0) phase <= PH_IDLE;
                    else            beat  <= beat - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.snap_clr = irq_go;
        ctl.push     = (phase == PH_SAVE);
        ctl.pop      = (phase == PH_REST);
    end

    assign stall = (!idle && (irq_req || reti_req))
                 || ((phase == PH_REST) && (rd_en || wr_en))
                 || (idle && reti_req && irq_req && frame_ok);

    assign save_busy = (phase == PH_SAVE);
    assign save_done = (phase == PH_SAVE) && (beat == LAST);
    assign rest_busy = (phase == PH_REST);
    assign rest_done = (phase == PH_REST) && (beat == '0);
    assign stack_ovf = idle && irq_req && !room_ok;
    assign stack_unf = idle && reti_req && !irq_req && !frame_ok;

    // R6: a restore never directly follows a save cycle
    a_r6_no_restore_after_save: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_SAVE) |-> (phase != PH_REST));

    // R2: save beats advance one per cycle
    a_r2_save_steps: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SAVE && beat != LAST) |=> (phase == PH_SAVE && beat == $past(beat) + 1'b1));

    // R7: restore beats retreat one per cycle
    a_r7_rest_steps: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REST && beat != '0) |=> (phase == PH_REST && beat == $past(beat) - 1'b1));

endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
    parameter int BEATW = 64,
    parameter int DEPTH = 16,
    parameter int BEATS = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [BEATW-1:0] din,
    output logic [BEATW-1:0] dout,
    output logic             room_ok,
    output logic             frame_ok
);

    logic [BEATW-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;
    logic [PW-1:0]    below;

    assign below = ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push) begin
            mem[ptr[AW-1:0]] <= din;
            ptr <= ptr + 1'b1;
        end else if (pop) begin
            ptr <= below;
        end
    end

    assign dout     = (ptr != '0) ? mem[below[AW-1:0]] : '0;
    assign room_ok  = (ptr <= PW'(DEPTH - BEATS));
    assign frame_ok = (ptr >= PW'(BEATS));

    // R10: pointer never passes the stack depth
    a_r10_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(DEPTH));

    // R2: each save beat advances the pointer by one
    a_r2_push_advance: assert property (@(posedge clk) disable iff (rst)
        push |=> (ptr == $past(ptr) + 1'b1));

    // R11: nothing is popped from an empty stack
    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (ptr != '0));

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int BEATS = 8,
    localparam int RPB   = ctx_pkg::regs_per_beat(NREG, BEATS),
    localparam int BEATW = RPB * DW,
    localparam int IW    = $clog2(NREG),
    localparam int BCW   = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_clr,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             rest_wr,
    input  logic [BCW-1:0]   beat,
    input  logic [BEATW-1:0] rest_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [BEATW-1:0] save_data
);

    logic [DW-1:0] live [NREG];
    logic [DW-1:0] snap [NREG];
    logic [DW-1:0] live_or;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                live[i] <= '0;
                snap[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (snap_clr) begin
                    snap[i] <= (wr_en && wr_idx == IW'(i)) ? wr_data : live[i];
                    live[i] <= '0;
                end else if (rest_wr && (i / RPB) == int'(beat)) begin
                    live[i] <= rest_data[(i % RPB) * DW +: DW];
                end else if (wr_en && wr_idx == IW'(i)) begin
                    live[i] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        for (int k = 0; k < RPB; k++) begin
            save_data[k * DW +: DW] = snap[int'(beat) * RPB + k];
        end
    end

    always_comb begin
        live_or = '0;
        for (int i = 0; i < NREG; i++) live_or = live_or | live[i];
    end

    assign rd_data = live[rd_idx];

    // R4: every live register is zero right after the snapshot
    a_r4_cleared: assert property (@(posedge clk) disable iff (rst)
        snap_clr |=> (live_or == '0));

    // R3: a write in the snapshot cycle is captured
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        (snap_clr && wr_en) |=> (snap[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int DW     = 32,
    parameter int BEATS  = 8,
    parameter int FRAMES = 2,
    localparam int IW    = $clog2(NREG),
    localparam int BCW   = $clog2(BEATS),
    localparam int RPB   = regs_per_beat(NREG, BEATS),
    localparam int BEATW = RPB * DW,
    localparam int DEPTH = FRAMES * BEATS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          reti_req,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          stall,
    output logic          save_busy,
    output logic          save_done,
    output logic          rest_busy,
    output logic          rest_done,
    output logic          stack_ovf,
    output logic          stack_unf
);

    ctx_ctl_t         ctl;
    ctx_phase_e       phase;
    logic [BCW-1:0]   beat;
    logic             room_ok, frame_ok;
    logic             wr_ok;
    logic [BEATW-1:0] save_data, rest_data;

    assign wr_ok = wr_en && (phase != PH_REST);

    ctx_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .reti_req  (reti_req),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .room_ok   (room_ok),
        .frame_ok  (frame_ok),
        .ctl       (ctl),
        .phase     (phase),
        .beat      (beat),
        .stall     (stall),
        .save_busy (save_busy),
        .save_done (save_done),
        .rest_busy (rest_busy),
        .rest_done (rest_done),
        .stack_ovf (stack_ovf),
        .stack_unf (stack_unf)
    );

    ctx_stack #(.BEATW(BEATW), .DEPTH(DEPTH), .BEATS(BEATS)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .din      (save_data),
        .dout     (rest_data),
        .room_ok  (room_ok),
        .frame_ok (frame_ok)
    );

    ctx_regfile #(.NREG(NREG), .DW(DW), .BEATS(BEATS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .snap_clr  (ctl.snap_clr),
        .wr_en     (wr_ok),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rest_wr   (ctl.pop),
        .beat      (beat),
        .rest_data (rest_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .save_data (save_data)
    );

    // R6: save and restore never overlap
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(save_busy && rest_busy));

endmodule

// File: tb/ctx_seq_test.sv
module ctx_seq_test;

    localparam int NREG = 16, DW = 16, BEATS = 8, FRAMES = 1;
    localparam int IW = $clog2(NREG);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, irq_req, reti_req, wr_en, rd_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [DW-1:0] wr_data, rd_data;
    logic stall, save_busy, save_done, rest_busy, rest_done, stack_ovf, stack_unf;

    ctx_seq #(.NREG(NREG), .DW(DW), .BEATS(BEATS), .FRAMES(FRAMES)) uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .reti_req(reti_req),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .stall(stall), .save_busy(save_busy), .save_done(save_done),
        .rest_busy(rest_busy), .rest_done(rest_done),
        .stack_ovf(stack_ovf), .stack_unf(stack_unf)
    );

    int checks = 0, errors = 0;
    int n_save = 0, n_sdone = 0, n_rest = 0, n_rdone = 0;

    typedef struct {
        logic [DW-1:0] exp;
        int            idx;
        string         tag;
    } rd_item_t;
    rd_item_t sb[$];

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(16'h1000 + i * 257);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: a read completes when it is presented and not stalled
    always @(negedge clk) begin
        if (!rst && rd_en && !stall) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected read", int'(rd_data), 0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                chk(rd_data === it.exp, it.tag, $sformatf("reg%0d", it.idx),
                    int'(rd_data), int'(it.exp));
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (save_busy) n_save++;
            if (save_done) n_sdone++;
            if (rest_busy) n_rest++;
            if (rest_done) n_rdone++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_read(input int idx, input logic [DW-1:0] exp,
                           input string tag, output bit stalled);
        rd_item_t it;
        it.exp = exp; it.idx = idx; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; rd_idx = IW'(idx); stalled = 1'b0;
        @(negedge clk);
        while (stall) begin
            stalled = 1'b1;
            @(negedge clk);
        end
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic do_write(input int idx, input logic [DW-1:0] data);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit st;
        bit seen;
        rst = 1'b1; irq_req = 1'b0; reti_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_idx = '0; rd_idx = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk(stall == 1'b0, "R1", "stall", stall, 0);
        chk(!save_busy && !rest_busy && !save_done && !rest_done, "R1", "busy/done", 0, 0);
        chk(!stack_ovf && !stack_unf, "R1", "stack flags", int'({stack_ovf, stack_unf}), 0);
        tick();
        do_read(0, '0, "R1", st);

        for (int i = 0; i < NREG; i++) do_write(i, pat(i));
        do_read(4, pat(4), "R7", st);

        // interrupt with a pending write to reg5 in the same cycle (R3)
        irq_req = 1'b1; wr_en = 1'b1; wr_idx = IW'(5); wr_data = 16'hBEEF;
        @(negedge clk);
        chk(stall == 1'b0, "R2", "stall on accept", stall, 0);
        tick();
        irq_req = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk(save_busy == 1'b1, "R2", "save_busy after accept", save_busy, 1);
        tick();
        do_read(3, '0, "R4", st);                 // cleared after sample
        chk(!st, "R5", "read stalled during save", st, 0);
        do_write(2, 16'h2222);                    // handler write during save
        do_read(2, 16'h2222, "R5", st);
        chk(!st, "R5", "read stalled during save", st, 0);

        // return held while save drains (R6)
        reti_req = 1'b1; seen = 1'b0;
        @(negedge clk);
        while (stall) begin
            seen = 1'b1;
            chk(save_busy == 1'b1, "R6", "stall only while saving", save_busy, 1);
            @(negedge clk);
        end
        chk(seen, "R6", "return was stalled", seen, 1);
        chk(save_busy == 1'b0, "R6", "save_busy at accept", save_busy, 0);
        tick();
        reti_req = 1'b0;

        // restore running: write and interrupt are stalled (R8)
        wr_en = 1'b1; wr_idx = IW'(7); wr_data = 16'h7777; irq_req = 1'b1;
        @(negedge clk);
        chk(stall == 1'b1, "R8", "stall on write in restore", stall, 1);
        chk(rest_busy == 1'b1, "R7", "rest_busy", rest_busy, 1);
        tick();
        wr_en = 1'b0; irq_req = 1'b0;

        do_read(0, pat(0), "R9", st);
        chk(st, "R9", "first read stalled", st, 1);
        for (int i = 1; i < NREG; i++) begin
            if (i == 5)      do_read(i, 16'hBEEF, "R3", st);
            else if (i == 7) do_read(i, pat(7), "R8", st);
            else             do_read(i, pat(i), "R7", st);
        end

        // underflow (R11)
        reti_req = 1'b1;
        @(negedge clk);
        chk(stack_unf == 1'b1, "R11", "stack_unf", stack_unf, 1);
        chk(stall == 1'b0, "R11", "stall", stall, 0);
        tick();
        reti_req = 1'b0;
        @(negedge clk);
        chk(rest_busy == 1'b0, "R11", "rest_busy", rest_busy, 0);
        tick();

        // second interrupt fills the one-frame stack
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        repeat (10) tick();
        do_write(1, 16'h4444);

        // overflow (R10)
        irq_req = 1'b1;
        @(negedge clk);
        chk(stack_ovf == 1'b1, "R10", "stack_ovf", stack_ovf, 1);
        chk(stall == 1'b0, "R10", "stall", stall, 0);
        tick();
        irq_req = 1'b0;
        @(negedge clk);
        chk(save_busy == 1'b0, "R10", "save_busy", save_busy, 0);
        tick();
        do_read(1, 16'h4444, "R10", st);

        reti_req = 1'b1;
        tick();
        reti_req = 1'b0;
        do_read(1, pat(1), "R7", st);
        do_read(5, 16'hBEEF, "R3", st);
        repeat (2) tick();

        chk(n_save == 2 * BEATS, "R2", "save_busy cycles", n_save, 2 * BEATS);
        chk(n_sdone == 2, "R2", "save_done pulses", n_sdone, 2);
        chk(n_rest == 2 * BEATS, "R7", "rest_busy cycles", n_rest, 2 * BEATS);
        chk(n_rdone == 2, "R7", "rest_done pulses", n_rdone, 2);
        chk(sb.size() == 0, "R9", "pending reads", sb.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule